// File: doc/BRIEF.md
# Multi-Lane FIFO Read Alignment Controller

This block starts reading a group of parallel receive-lane FIFOs in one and the same cycle, so the words at the FIFO outputs line up across lanes. Each lane FIFO reports an empty flag. The controller waits until the lanes it watches have all gone non-empty. It then raises a single read enable that is fanned out to every used lane. That enable stays high for as long as the link is up.

Two build-time configurations are offered. When every lane is captured by its own clock or strobe, all lanes picked by a lane mask are combined, and the last lane to fill releases the read. When all lanes share one capture clock, only the lane at the far end of the clock distribution is watched, because it is the last to receive data.

Zero to three retiming registers may sit between the empty-flag logic and the enable, to ease timing. An interface-ready input keeps the enable and the downstream valid low until the link is initialised, and it drops both at once when the link goes down. The valid output is the enable delayed by the FIFO read latency, so it marks the first aligned word.

Top module: `lane_read_align`

## Requirements
- R1: While `rst_n` is low, `lane_rd_en` is all zeros and `data_valid` is 0, whatever the empty flags and `link_ready` show.
- R2: With `SINGLE_CLK` = 0, the enable is released only once every lane whose `LANE_MASK` bit is 1 shows `lane_empty` = 0. A single used lane that is still empty (bit i of `lane_empty` is lane i) keeps the enable low indefinitely.
- R3: Lanes whose `LANE_MASK` bit is 0 have no effect on when the enable is released, and their `lane_rd_en` bit stays 0.
- R4: With `SINGLE_CLK` = 1, only `lane_empty[FAR_LANE]` gates the release. Other lanes being empty does not delay it. The far lane being empty blocks it.
- R5: With `RETIME_STAGES` = S, `lane_rd_en` rises exactly S clock edges after the cycle in which the release condition first holds. With S = 0 it rises combinationally in that same cycle.
- R6: Once raised, the enable stays high while `link_ready` stays high, even if empty flags go high again.
- R7: While `link_ready` is 0, `lane_rd_en` is all zeros and `data_valid` is 0. Both fall in the same cycle that `link_ready` falls.
- R8: With `VALID_LATENCY` = L, `data_valid` rises exactly L clock edges after `lane_rd_en` rises.
- R9: After `link_ready` has been low, reading restarts only on a fresh release condition, again through S retiming stages. No earlier enable or valid history survives.
- R10: All used lanes receive an identical enable: `lane_rd_en` equals either all zeros or exactly `LANE_MASK`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Read-side clock shared with the lane FIFOs |
| rst_n | input | 1 | Synchronous active-low reset |
| lane_empty | input | NUM_LANES | Empty flag of each lane FIFO, bit i for lane i |
| link_ready | input | 1 | Interface initialised and running |
| lane_rd_en | output | NUM_LANES | Common read enable, copied to every used lane |
| data_valid | output | 1 | First and following aligned words present at the FIFO outputs |

## Verification
The hardest case to reach is a lane that fills late while the other lanes are already non-empty. The enable must then wait for that last lane, while a lane outside the mask, or a non-far lane in the single-clock build, stays empty without holding anything up. The bench runs three builds in parallel from the same empty-flag vector: masked multi-clock with one retiming stage, single-clock with two stages, and combinational multi-clock. A single pattern, with one unused lane left empty, therefore releases one build while it must hold back another. A second delicate point is dropping and re-raising `link_ready` while the valid delay line is full. The bench does this and checks that no stale valid leaks out after the restart.

// File: rtl/lra_pkg.sv
// Package: shared limits and mode type for the lane read alignment block.
// Assumes: all lanes run on the read clock of the alignment controller.
package lra_pkg;

    localparam int MAX_LANES   = 8;
    localparam int MAX_RETIME  = 3;
    localparam int MAX_LATENCY = 8;

    typedef enum logic {
        COMBINE_ALL_USED = 1'b0,
        COMBINE_FAR_ONLY = 1'b1
    } combine_mode_e;

    // Select the combine mode from the single-clock build switch.
    function automatic combine_mode_e mode_from_bit(input bit single_clk);
        return single_clk ? COMBINE_FAR_ONLY : COMBINE_ALL_USED;
    endfunction

endpackage

// File: rtl/lra_empty_combine.sv
// Module: lra_empty_combine
// Turns the lane empty flags into one "all watched lanes hold data" flag.
// In COMBINE_ALL_USED mode every lane with its mask bit set must be non-empty
// (a NOR of the masked empty flags). In COMBINE_FAR_ONLY mode only the lane
// at the end of the clock distribution is watched.
// Assumes: the mask has at least one bit set and FAR_LANE < NUM_LANES.
module lra_empty_combine
    import lra_pkg::*;
#(
    parameter int                  NUM_LANES = 4,
    parameter logic [NUM_LANES-1:0] LANE_MASK = '1,
    parameter combine_mode_e       MODE      = COMBINE_ALL_USED,
    parameter int                  FAR_LANE  = NUM_LANES - 1
) (
    input  logic [NUM_LANES-1:0] lane_empty,
    output logic                 lanes_filled
);

    generate
        if (MODE == COMBINE_FAR_ONLY) begin : g_far
            // Watch the far lane alone.
            assign lanes_filled = ~lane_empty[FAR_LANE];
        end else begin : g_all
            logic [NUM_LANES-1:0] lane_ok;
            for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
                if (LANE_MASK[i]) begin : g_used
                    // A used lane counts once it holds data.
                    assign lane_ok[i] = ~lane_empty[i];
                end else begin : g_unused
                    // An unused lane never holds the release back.
                    assign lane_ok[i] = 1'b1;
                end
            end
            // AND of per-lane readiness equals NOR of masked empties.
            assign lanes_filled = &lane_ok;
        end
    endgenerate

endmodule

// File: rtl/lra_retime_pipe.sv
// Module: lra_retime_pipe
// Delays the release condition by STAGES registers to ease timing.
// A clear input flushes the stages so no stale release survives a link drop.
// With STAGES = 0 the condition passes straight through.
// Assumes: 0 <= STAGES <= MAX_RETIME.
module lra_retime_pipe
    import lra_pkg::*;
#(
    parameter int STAGES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic d,
    output logic q
);

    generate
        if (STAGES == 0) begin : g_bypass
            // No retiming: the release is combinational.
            assign q = d;
        end else begin : g_regs
            logic [STAGES-1:0] stage_q;

            // Shift the release condition through the retiming stages.
            always_ff @(posedge clk) begin
                if (!rst_n || clear) begin
                    stage_q <= '0;
                end else begin
                    for (int i = STAGES - 1; i > 0; i--) begin
                        stage_q[i] <= stage_q[i-1];
                    end
                    stage_q[0] <= d;
                end
            end

            assign q = stage_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/lra_enable_hold.sv
// Module: lra_enable_hold
// Keeps the common read enable high once the retimed release has arrived,
// until reset or until the link drops. The link qualifier acts
// combinationally, so the enable falls in the same cycle as link_ready.
// Assumes: release_in is already cleared while the link is down.
module lra_enable_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic link_ready,
    input  logic release_in,
    output logic rd_en
);

    logic held_q;
    logic rd_en_next;

    // Enable is on when the link is up and the release was seen now or earlier.
    always_comb begin
        rd_en_next = link_ready & (held_q | release_in);
    end

    // Remember that reading has started.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= 1'b0;
        end else begin
            held_q <= rd_en_next;
        end
    end

    assign rd_en = rd_en_next;

endmodule

// File: rtl/lra_valid_delay.sv
// Module: lra_valid_delay
// Delays the read enable by the FIFO read latency to mark valid words.
// The line is flushed while the link is down, and the output is gated by
// the link status so downstream logic stays idle until the link is up.
// Assumes: 1 <= LATENCY <= MAX_LATENCY.
module lra_valid_delay
    import lra_pkg::*;
#(
    parameter int LATENCY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic link_ready,
    input  logic rd_en,
    output logic data_valid
);

    logic [LATENCY-1:0] line_q;

    // Shift the read enable along the read-latency delay line.
    always_ff @(posedge clk) begin
        if (!rst_n || !link_ready) begin
            line_q <= '0;
        end else begin
            for (int i = LATENCY - 1; i > 0; i--) begin
                line_q[i] <= line_q[i-1];
            end
            line_q[0] <= rd_en;
        end
    end

    // Gate the valid with the link status.
    always_comb begin
        data_valid = line_q[LATENCY-1] & link_ready;
    end

endmodule

// File: rtl/lane_read_align.sv
// Module: lane_read_align (top)
// Starts reading all used lane FIFOs in the same cycle. The empty flags are
// combined per the build mode, optionally retimed, held as a sticky enable
// qualified by link_ready, fanned out to used lanes, and delayed into a
// downstream valid.
// Assumes: lane FIFOs and this block share clk; the mask is non-zero;
// FAR_LANE names a used lane in the single-clock build.
module lane_read_align
    import lra_pkg::*;
#(
    parameter int                   NUM_LANES     = 4,
    parameter logic [NUM_LANES-1:0] LANE_MASK     = 4'b1011,
    parameter bit                   SINGLE_CLK    = 1'b0,
    parameter int                   FAR_LANE      = NUM_LANES - 1,
    parameter int                   RETIME_STAGES = 1,
    parameter int                   VALID_LATENCY = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LANES-1:0] lane_empty,
    input  logic                 link_ready,
    output logic [NUM_LANES-1:0] lane_rd_en,
    output logic                 data_valid
);

    localparam combine_mode_e MODE = mode_from_bit(SINGLE_CLK);

    logic lanes_filled;
    logic release_now;
    logic release_rt;
    logic rd_en_common;

    lra_empty_combine #(
        .NUM_LANES (NUM_LANES),
        .LANE_MASK (LANE_MASK),
        .MODE      (MODE),
        .FAR_LANE  (FAR_LANE)
    ) u_combine (
        .lane_empty   (lane_empty),
        .lanes_filled (lanes_filled)
    );

    // Release condition: out of reset, link up, watched lanes all hold data.
    always_comb begin
        release_now = rst_n & link_ready & lanes_filled;
    end

    lra_retime_pipe #(
        .STAGES (RETIME_STAGES)
    ) u_retime (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (~link_ready),
        .d     (release_now),
        .q     (release_rt)
    );

    lra_enable_hold u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .link_ready (link_ready),
        .release_in (release_rt),
        .rd_en      (rd_en_common)
    );

    // Fan the common enable out to used lanes only.
    always_comb begin
        lane_rd_en = {NUM_LANES{rd_en_common}} & LANE_MASK;
    end

    lra_valid_delay #(
        .LATENCY (VALID_LATENCY)
    ) u_valid (
        .clk        (clk),
        .rst_n      (rst_n),
        .link_ready (link_ready),
        .rd_en      (rd_en_common),
        .data_valid (data_valid)
    );

endmodule

// File: rtl/lra_checker.sv
// Module: lra_checker
// Property checks for lane_read_align, attached to it by bind below.
// Keeps its own view of "release seen" and "enable seen" from the ports.
module lra_checker #(
    parameter int                   NUM_LANES  = 4,
    parameter logic [NUM_LANES-1:0] LANE_MASK  = '1,
    parameter bit                   SINGLE_CLK = 1'b0,
    parameter int                   FAR_LANE   = NUM_LANES - 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_LANES-1:0] lane_empty,
    input logic                 link_ready,
    input logic [NUM_LANES-1:0] lane_rd_en,
    input logic                 data_valid
);

    logic cond_ok;
    logic cond_seen_q;
    logic rd_seen_q;

    // Watched lanes all non-empty, as seen at the ports.
    always_comb begin
        if (SINGLE_CLK) cond_ok = ~lane_empty[FAR_LANE];
        else            cond_ok = ((~lane_empty) & LANE_MASK) == LANE_MASK;
    end

    // Track whether a release condition and an enable occurred since link up.
    always_ff @(posedge clk) begin
        if (!rst_n || !link_ready) begin
            cond_seen_q <= 1'b0;
            rd_seen_q   <= 1'b0;
        end else begin
            if (cond_ok)     cond_seen_q <= 1'b1;
            if (|lane_rd_en) rd_seen_q   <= 1'b1;
        end
    end

    // R10: one enable shared by exactly the used lanes
    assert_same_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((lane_rd_en & ~LANE_MASK) == '0) &&
        ($countones(lane_rd_en) == 0 || $countones(lane_rd_en) == $countones(LANE_MASK)));

    // R7: nothing reads or is valid while the link is down
    assert_link_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !link_ready |-> (lane_rd_en == '0 && !data_valid));

    // R6: enable is sticky while the link stays up
    assert_enable_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((|lane_rd_en) && link_ready) |=> (!link_ready || (|lane_rd_en)));

    // R2: reading never starts before the watched lanes have filled
    assert_start_needs_lanes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|lane_rd_en) |-> (cond_seen_q || (cond_ok && link_ready)));

    // R8: valid only follows an enable seen since link up
    assert_valid_after_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_valid) |-> rd_seen_q);

endmodule

bind lane_read_align lra_checker #(
    .NUM_LANES  (NUM_LANES),
    .LANE_MASK  (LANE_MASK),
    .SINGLE_CLK (SINGLE_CLK),
    .FAR_LANE   (FAR_LANE)
) u_lra_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .lane_empty (lane_empty),
    .link_ready (link_ready),
    .lane_rd_en (lane_rd_en),
    .data_valid (data_valid)
);

// File: tb/test_lane_read_align.sv
`timescale 1ns/1ps
// Directed bench: three builds share one stimulus.
//  a: multi-clock, mask 1011, 1 retime stage, latency 2
//  b: single-clock far lane 3, mask 1111, 2 stages, latency 3
//  c: multi-clock, mask 1111, no retiming, latency 1
module test_lane_read_align;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] empty = 4'b1111;
    logic       ready = 1'b1;
    logic [3:0] rd_a, rd_b, rd_c;
    logic       va, vb, vc;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    lane_read_align #(.NUM_LANES(4), .LANE_MASK(4'b1011), .SINGLE_CLK(1'b0),
        .FAR_LANE(3), .RETIME_STAGES(1), .VALID_LATENCY(2)) i_lane_read_align (
        .clk(clk), .rst_n(rst_n), .lane_empty(empty), .link_ready(ready),
        .lane_rd_en(rd_a), .data_valid(va));

    lane_read_align #(.NUM_LANES(4), .LANE_MASK(4'b1111), .SINGLE_CLK(1'b1),
        .FAR_LANE(3), .RETIME_STAGES(2), .VALID_LATENCY(3)) i_lane_read_align_sgl (
        .clk(clk), .rst_n(rst_n), .lane_empty(empty), .link_ready(ready),
        .lane_rd_en(rd_b), .data_valid(vb));

    lane_read_align #(.NUM_LANES(4), .LANE_MASK(4'b1111), .SINGLE_CLK(1'b0),
        .FAR_LANE(3), .RETIME_STAGES(0), .VALID_LATENCY(1)) i_lane_read_align_comb (
        .clk(clk), .rst_n(rst_n), .lane_empty(empty), .link_ready(ready),
        .lane_rd_en(rd_c), .data_valid(vc));

    task automatic chk(input string req, input string what,
                       input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ready = 1'b1; empty = 4'b1111;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R1: outputs stay low in reset even with all lanes filled
    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0; empty = 4'b0000; ready = 1'b1;
        #1;
        chk("R1", "rd_c in reset", rd_c, 4'b0000);
        repeat (3) @(negedge clk);
        chk("R1", "rd_a in reset", rd_a, 4'b0000);
        chk("R1", "rd_b in reset", rd_b, 4'b0000);
        chk("R1", "rd_c held reset", rd_c, 4'b0000);
        chk("R1", "valids in reset", {1'b0, va, vb, vc}, 4'b0000);
        empty = 4'b1111;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "rd after reset", rd_a | rd_b | rd_c, 4'b0000);
    endtask

    // R2 R3 R5 R6 R8 R10: masked release, timing, stickiness
    task automatic t_multi();
        do_reset();
        empty = 4'b0100;               // only unused-in-a lane 2 empty
        #1;
        chk("R5", "rd_a before retime edge", rd_a, 4'b0000);
        chk("R2", "rd_c blocked by lane 2", rd_c, 4'b0000);
        @(negedge clk);
        chk("R3", "rd_a ignores unused lane", rd_a, 4'b1011);
        chk("R10", "rd_a only used lanes", rd_a & 4'b0100, 4'b0000);
        chk("R5", "rd_b after 1 of 2 stages", rd_b, 4'b0000);
        @(negedge clk);
        chk("R5", "rd_b after 2 stages", rd_b, 4'b1111);
        chk("R8", "va after 1 of 2", {3'b0, va}, 4'b0000);
        @(negedge clk);
        chk("R8", "va after latency 2", {3'b0, va}, 4'b0001);
        chk("R2", "rd_c still blocked", rd_c, 4'b0000);
        @(negedge clk);
        chk("R8", "vb after 2 of 3", {3'b0, vb}, 4'b0000);
        @(negedge clk);
        chk("R8", "vb after latency 3", {3'b0, vb}, 4'b0001);
        empty = 4'b0000;               // last lane fills
        #1;
        chk("R5", "rd_c combinational", rd_c, 4'b1111);
        chk("R8", "vc not yet", {3'b0, vc}, 4'b0000);
        @(negedge clk);
        chk("R8", "vc after latency 1", {3'b0, vc}, 4'b0001);
        empty = 4'b1111;               // flags return high
        repeat (3) @(negedge clk);
        chk("R6", "rd_a sticky", rd_a, 4'b1011);
        chk("R6", "rd_b sticky", rd_b, 4'b1111);
        chk("R6", "rd_c sticky", rd_c, 4'b1111);
        chk("R6", "valids sticky", {1'b0, va, vb, vc}, 4'b0111);
    endtask

    // R4: single-clock build watches only the far lane
    task automatic t_single();
        do_reset();
        empty = 4'b1000;               // far lane empty, others filled
        repeat (4) @(negedge clk);
        chk("R4", "rd_b blocked by far lane", rd_b, 4'b0000);
        chk("R2", "rd_a blocked by lane 3", rd_a, 4'b0000);
        empty = 4'b0111;               // far lane filled, others empty
        @(negedge clk);
        chk("R4", "rd_b after 1 stage", rd_b, 4'b0000);
        @(negedge clk);
        chk("R4", "rd_b ignores near lanes", rd_b, 4'b1111);
        chk("R2", "rd_a needs lanes 0,1", rd_a, 4'b0000);
        chk("R2", "rd_c needs all", rd_c, 4'b0000);
    endtask

    // R7 R9: link status gating and restart
    task automatic t_ready();
        do_reset();
        ready = 1'b0; empty = 4'b0000;
        repeat (4) @(negedge clk);
        chk("R7", "no enable while link down", rd_a | rd_b | rd_c, 4'b0000);
        chk("R7", "no valid while link down", {1'b0, va, vb, vc}, 4'b0000);
        ready = 1'b1;
        #1;
        chk("R7", "rd_c on link up", rd_c, 4'b1111);
        @(negedge clk);
        chk("R7", "rd_a on link up", rd_a, 4'b1011);
        @(negedge clk);
        chk("R7", "rd_b on link up", rd_b, 4'b1111);
        repeat (4) @(negedge clk);
        chk("R8", "all valids up", {1'b0, va, vb, vc}, 4'b0111);
        ready = 1'b0;
        #1;
        chk("R7", "enables drop with link", rd_a | rd_b | rd_c, 4'b0000);
        chk("R7", "valids drop with link", {1'b0, va, vb, vc}, 4'b0000);
        @(negedge clk);
        ready = 1'b1; empty = 4'b1111;
        repeat (4) @(negedge clk);
        chk("R9", "no enable without fresh release", rd_a | rd_b | rd_c, 4'b0000);
        chk("R9", "no stale valid", {1'b0, va, vb, vc}, 4'b0000);
        empty = 4'b0000;
        #1;
        chk("R9", "rd_a waits retime stage", rd_a, 4'b0000);
        @(negedge clk);
        chk("R9", "rd_a restarts", rd_a, 4'b1011);
        chk("R9", "va not early after restart", {3'b0, va}, 4'b0000);
    endtask

    initial begin
        t_reset();
        t_multi();
        t_single();
        t_ready();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule